// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block sits between a simple word-wide bus and the data path of a serial port. It decodes bus accesses to four 32-bit registers (configuration, receive character, transmit character and status), keeps the line configuration that the serializers use, and turns accesses into push and pop strobes for the external transmit and receive FIFOs. The FIFO storage and the shift logic live elsewhere; this block only sees their flags and fill counts.

The status word mixes sticky event flags with live FIFO and line signals. The sticky flags are cleared by writing ones to them. A single active-high interrupt line is formed from the receive and transmit pending flags, each gated by its own enable. Clearing the global enable holds both FIFOs in flush and blocks transmit pushes.

Bus reads are registered: the read word appears on the data output the cycle after the request and holds until the next read. Byte offsets: configuration 0x0, receive character 0x4, transmit character 0x8, status 0xC; any other offset reads as zero.

Top module: `uart_regif`

## Requirements
- R1: The configuration register resets to zero, stores bits [1:0] word length, [2] two-stop select, [6:4] parity mode, [12] auto flow, [14] level source, [15] enable, [16] receive DMA enable, [17] transmit DMA enable, [18] receive interrupt enable, [19] transmit interrupt enable, [20] loopback, and reads all other bits as zero.
- R2: A write to offset 0x8 while enabled and the transmit FIFO is not full pushes write bits [7:0]; while the FIFO is full it pushes nothing and sets status bit [3].
- R3: A read of offset 0x4 with the receive FIFO not empty pops one entry and returns the character in bits [7:0] with bits [31:8] zero; with the FIFO empty it returns zero and does not pop.
- R4: Status bit [0] sets while bit [18] is 1 and the receive FIFO is not empty; status bit [1] sets while bit [19] is 1 and the transmit FIFO is not full; both stay set once set.
- R5: Writing offset 0xC clears each of status bits [4:0] whose write bit is 1 and leaves those written 0; a set condition in the same cycle wins over the clear.
- R6: A pulse on the receive overrun input sets status bit [2]; a pulse on the receive frame error input sets status bit [4].
- R7: The interrupt output is high exactly when (bit [0] and enable bit [18]) or (bit [1] and enable bit [19]).
- R8: Status bits [16:11] show the transmit FIFO count when configuration bit [14] is 1 and the receive count when it is 0, saturated at 63.
- R9: Status bit [5] shows receive empty, [6] transmit full, [7] the CTS input ORed with the inverse of bit [12], [8] the RTS input, [10] transmit empty and [17] the busy input.
- R10: With bit [15] at 0 the flush output is high and transmit writes neither push nor set bit [3].
- R11: The configuration fields drive the word length, stop, parity, flow, enable, DMA enable and loopback outputs directly.
- R12: Read data appears on the data output one cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 8 | Character to push |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_count_i | input | TX_CW | Transmit FIFO fill count |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| rx_data_i | input | 8 | Receive FIFO head character |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_count_i | input | RX_CW | Receive FIFO fill count |
| rx_overrun_i | input | 1 | Receive overrun event pulse |
| rx_frame_err_i | input | 1 | Receive parity or framing error pulse |
| cts_i | input | 1 | Clear-to-send line state |
| rts_i | input | 1 | Request-to-send line state |
| busy_i | input | 1 | Serializer busy |
| word_len_o | output | 2 | Character length code |
| two_stop_o | output | 1 | Two stop bits |
| parity_o | output | 3 | Parity mode code |
| flow_en_o | output | 1 | Automatic flow control |
| serial_en_o | output | 1 | Port enable |
| flush_o | output | 1 | Hold both FIFOs flushed |
| rx_dma_en_o | output | 1 | Receive DMA enable |
| tx_dma_en_o | output | 1 | Transmit DMA enable |
| loopback_o | output | 1 | Internal loopback |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with a 64-entry transmit FIFO and a 16-entry receive FIFO, so the transmit count input can reach 64 and the level field's saturation at 63 is observable, while the receive side stays below the cap. Random configuration words and random live flag and count values exercise the level source select and the CTS masking, and directed sequences cover the sticky pending flags, set-over-clear collisions and the disabled state.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int OFF_CTRL = 'h0;
  localparam int OFF_RXD  = 'h4;
  localparam int OFF_TXD  = 'h8;
  localparam int OFF_STAT = 'hC;

  localparam int NUM_EVT = 5;
  localparam int EV_RX   = 0;
  localparam int EV_TX   = 1;
  localparam int EV_OVR  = 2;
  localparam int EV_TXE  = 3;
  localparam int EV_RXS  = 4;

  localparam int LVL_W   = 6;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  typedef struct packed {
    logic       loopback;
    logic       tx_ie;
    logic       rx_ie;
    logic       tx_de;
    logic       rx_de;
    logic       en;
    logic       lvl_tx;
    logic       afe;
    logic [2:0] parity;
    logic       two_stop;
    logic [1:0] wlen;
  } cfg_t;

  function automatic cfg_t cfg_unpack(logic [31:0] w);
    cfg_t c;
    c.wlen     = w[1:0];
    c.two_stop = w[2];
    c.parity   = w[6:4];
    c.afe      = w[12];
    c.lvl_tx   = w[14];
    c.en       = w[15];
    c.rx_de    = w[16];
    c.tx_de    = w[17];
    c.rx_ie    = w[18];
    c.tx_ie    = w[19];
    c.loopback = w[20];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(cfg_t c);
    logic [31:0] w;
    w       = '0;
    w[1:0]  = c.wlen;
    w[2]    = c.two_stop;
    w[6:4]  = c.parity;
    w[12]   = c.afe;
    w[14]   = c.lvl_tx;
    w[15]   = c.en;
    w[16]   = c.rx_de;
    w[17]   = c.tx_de;
    w[18]   = c.rx_ie;
    w[19]   = c.tx_ie;
    w[20]   = c.loopback;
    return w;
  endfunction
endpackage

// File: rtl/uart_regif_cfg.sv
module uart_regif_cfg
  import uart_regif_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output cfg_t        cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (we_i) cfg_o <= cfg_unpack(wdata_i);
  end
endmodule

// File: rtl/uart_regif_evt.sv
module uart_regif_evt #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_regif_rd.sv
module uart_regif_rd
  import uart_regif_pkg::*;
#(
  parameter int TX_CW = 5,
  parameter int RX_CW = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [3:0]         sel_i,   // one-hot: cfg, rxd, txd, stat
  input  cfg_t               cfg_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [7:0]         rx_char_i,
  input  logic               rx_empty_i,
  input  logic               tx_full_i,
  input  logic               tx_empty_i,
  input  logic [TX_CW-1:0]   tx_count_i,
  input  logic [RX_CW-1:0]   rx_count_i,
  input  logic               cts_i,
  input  logic               rts_i,
  input  logic               busy_i,
  output logic [31:0]        rdata_o
);
  logic [31:0] cnt_sel;
  logic [LVL_W-1:0] lvl;
  logic [31:0] stat_w, rd_w;

  always_comb begin
    cnt_sel = cfg_i.lvl_tx ? 32'(tx_count_i) : 32'(rx_count_i);
    lvl = (cnt_sel > LVL_MAX) ? LVL_W'(LVL_MAX) : cnt_sel[LVL_W-1:0];
    stat_w = '0;
    stat_w[NUM_EVT-1:0] = evt_i;
    stat_w[5]     = rx_empty_i;
    stat_w[6]     = tx_full_i;
    stat_w[7]     = cts_i | ~cfg_i.afe;
    stat_w[8]     = rts_i;
    stat_w[10]    = tx_empty_i;
    stat_w[16:11] = lvl;
    stat_w[17]    = busy_i;
  end

  always_comb begin
    rd_w = '0;
    unique case (1'b1)
      sel_i[0]: rd_w = cfg_pack(cfg_i);
      sel_i[1]: rd_w = rx_empty_i ? 32'h0 : {24'h0, rx_char_i};
      sel_i[3]: rd_w = stat_w;
      default:  rd_w = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_w;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int TX_CW    = $clog2(TX_DEPTH + 1),
  parameter int RX_CW    = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic [TX_CW-1:0]  tx_count_i,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_empty_i,
  input  logic [RX_CW-1:0]  rx_count_i,
  input  logic              rx_overrun_i,
  input  logic              rx_frame_err_i,
  input  logic              cts_i,
  input  logic              rts_i,
  input  logic              busy_i,
  output logic [1:0]        word_len_o,
  output logic              two_stop_o,
  output logic [2:0]        parity_o,
  output logic              flow_en_o,
  output logic              serial_en_o,
  output logic              flush_o,
  output logic              rx_dma_en_o,
  output logic              tx_dma_en_o,
  output logic              loopback_o,
  output logic              irq_o
);
  localparam int NREG = 4;
  localparam int OFFS [NREG] = '{OFF_CTRL, OFF_RXD, OFF_TXD, OFF_STAT};

  cfg_t cfg_q;
  logic [NREG-1:0] sel;
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_q;
  logic rd_req, wr_cfg, wr_txd, wr_stat, rd_rxd, tx_ovf;
  logic rx_ie, tx_ie;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign sel[i] = bus_req_i && (bus_addr_i == ADDR_W'(OFFS[i]));
  end

  assign rd_req  = bus_req_i & ~bus_we_i;
  assign wr_cfg  = sel[0] & bus_we_i;
  assign rd_rxd  = sel[1] & ~bus_we_i;
  assign wr_txd  = sel[2] & bus_we_i;
  assign wr_stat = sel[3] & bus_we_i;

  uart_regif_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(wr_cfg), .wdata_i(bus_wdata_i), .cfg_o(cfg_q)
  );

  assign rx_ie  = cfg_q.rx_ie;
  assign tx_ie  = cfg_q.tx_ie;

  assign tx_push_o = wr_txd & cfg_q.en & ~tx_full_i;
  assign tx_ovf    = wr_txd & cfg_q.en & tx_full_i;
  assign tx_data_o = bus_wdata_i[7:0];
  assign rx_pop_o  = rd_rxd & ~rx_empty_i;

  always_comb begin
    evt_set         = '0;
    evt_set[EV_RX]  = rx_ie & ~rx_empty_i;
    evt_set[EV_TX]  = tx_ie & ~tx_full_i;
    evt_set[EV_OVR] = rx_overrun_i;
    evt_set[EV_TXE] = tx_ovf;
    evt_set[EV_RXS] = rx_frame_err_i;
    evt_clr = wr_stat ? bus_wdata_i[NUM_EVT-1:0] : '0;
  end

  uart_regif_evt #(.N(NUM_EVT)) u_evt (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(evt_clr), .q_o(evt_q)
  );

  assign irq_o = (evt_q[EV_RX] & rx_ie) | (evt_q[EV_TX] & tx_ie);

  uart_regif_rd #(.TX_CW(TX_CW), .RX_CW(RX_CW)) u_rd (
    .clk_i, .rst_ni,
    .rd_i(rd_req), .sel_i(sel), .cfg_i(cfg_q), .evt_i(evt_q),
    .rx_char_i(rx_data_i), .rx_empty_i, .tx_full_i, .tx_empty_i,
    .tx_count_i, .rx_count_i, .cts_i, .rts_i, .busy_i,
    .rdata_o(bus_rdata_o)
  );

  assign word_len_o  = cfg_q.wlen;
  assign two_stop_o  = cfg_q.two_stop;
  assign parity_o    = cfg_q.parity;
  assign flow_en_o   = cfg_q.afe;
  assign serial_en_o = cfg_q.en;
  assign flush_o     = ~cfg_q.en;
  assign rx_dma_en_o = cfg_q.rx_de;
  assign tx_dma_en_o = cfg_q.tx_de;
  assign loopback_o  = cfg_q.loopback;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_push_o,
  input logic       tx_full_i,
  input logic       rx_pop_o,
  input logic       rx_empty_i,
  input logic       serial_en_o,
  input logic       irq_o,
  input logic       rx_ie,
  input logic       tx_ie,
  input logic       wr_stat,
  input logic       clr0,
  input logic [4:0] evt_q
);
  a_r2_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> !tx_full_i);
  a_r3_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !rx_empty_i);
  a_r4_rx_pend_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ie && !rx_empty_i) |=> evt_q[0]);
  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && clr0 && !(rx_ie && !rx_empty_i)) |=> !evt_q[0]);
  a_r7_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rx_ie || tx_ie));
  a_r10_no_push_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serial_en_o |-> !tx_push_o);
endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_push_o(tx_push_o), .tx_full_i(tx_full_i),
  .rx_pop_o(rx_pop_o), .rx_empty_i(rx_empty_i), .serial_en_o(serial_en_o),
  .irq_o(irq_o), .rx_ie(rx_ie), .tx_ie(tx_ie), .wr_stat(wr_stat),
  .clr0(bus_wdata_i[0]), .evt_q(evt_q)
);

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
  localparam int TXD = 64, RXD = 16;
  localparam int TXW = $clog2(TXD + 1), RXW = $clog2(RXD + 1);
  localparam logic [31:0] CFG_MASK = 32'h001F_D077;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic tx_push, rx_pop, tx_full = 0, tx_empty = 1, rx_empty = 1;
  logic [7:0] tx_data, rx_data = 0;
  logic [TXW-1:0] tx_cnt = 0;
  logic [RXW-1:0] rx_cnt = 0;
  logic ovr = 0, ferr = 0, cts = 0, rts = 0, busy = 0;
  logic [1:0] wl; logic ts, fe, sen, fl, rde, tde, lb, irq;
  logic [2:0] par;
  int n_chk = 0, n_fail = 0;
  logic push_seen, pop_seen;
  logic [7:0] push_data;
  logic [31:0] r, cfg_w;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regif #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_push_o(tx_push), .tx_data_o(tx_data), .tx_full_i(tx_full),
    .tx_empty_i(tx_empty), .tx_count_i(tx_cnt), .rx_pop_o(rx_pop),
    .rx_data_i(rx_data), .rx_empty_i(rx_empty), .rx_count_i(rx_cnt),
    .rx_overrun_i(ovr), .rx_frame_err_i(ferr), .cts_i(cts), .rts_i(rts),
    .busy_i(busy), .word_len_o(wl), .two_stop_o(ts), .parity_o(par),
    .flow_en_o(fe), .serial_en_o(sen), .flush_o(fl), .rx_dma_en_o(rde),
    .tx_dma_en_o(tde), .loopback_o(lb), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    #1; push_seen = tx_push; push_data = tx_data;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1; pop_seen = rx_pop;
    @(negedge clk); req = 0; d = rdata;
  endtask

  function automatic logic [31:0] exp_stat(logic [31:0] c, logic [4:0] ev);
    int v;
    logic [31:0] s;
    v = c[14] ? int'(tx_cnt) : int'(rx_cnt);
    if (v > 63) v = 63;
    s = 32'(ev);
    s[5] = rx_empty; s[6] = tx_full; s[7] = cts | ~c[12];
    s[8] = rts; s[10] = tx_empty; s[16:11] = v[5:0]; s[17] = busy;
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R9 live bits, R12 read latency
    rd(12'h0, r); chk("R1 reset cfg", r, 0);
    chk("R11 reset enable", {31'h0, sen}, 0);
    rd(12'hC, r); chk("R9 reset status", r, 32'h0000_04A0);
    chk("R7 reset irq", {31'h0, irq}, 0);
    @(negedge clk); chk("R12 rdata holds", rdata, 32'h0000_04A0);
    rd(12'h10, r); chk("R12 unmapped reads zero", r, 0);
    // R1 mask, R11 outputs
    wr(12'h0, 32'hFFFF_FFFF);
    rd(12'h0, r); chk("R1 cfg mask", r, CFG_MASK);
    chk("R11 outputs", {20'h0, wl, ts, par, fe, sen, fl, rde, tde, lb},
        {20'h0, 2'd3, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1});
    wr(12'h0, 32'h0000_0056);
    chk("R11 fields", {24'h0, wl, ts, par}, {24'h0, 2'd2, 1'b1, 3'd5});
    wr(12'h0, 32'h0000_8000);
    wr(12'hC, 32'h1F);
    rd(12'hC, r); chk("R5 clear all", r[4:0], 0);
    // R2 push and overflow
    wr(12'h8, 32'h1A5);
    chk("R2 push", {23'h0, push_seen, push_data}, {23'h0, 1'b1, 8'hA5});
    tx_full = 1;
    wr(12'h8, 32'h33); chk("R2 no push full", {31'h0, push_seen}, 0);
    rd(12'hC, r); chk("R2 error bit", r[3], 1);
    wr(12'hC, 32'h0); rd(12'hC, r); chk("R5 write zero keeps", r[3], 1);
    wr(12'hC, 32'h8); rd(12'hC, r); chk("R5 w1c error", r[3], 0);
    // R10 disabled
    wr(12'h0, 32'h0);
    chk("R10 flush", {31'h0, fl}, 1);
    wr(12'h8, 32'h44); rd(12'hC, r); chk("R10 no error when off", r[3], 0);
    tx_full = 0;
    wr(12'h8, 32'h45); chk("R10 no push when off", {31'h0, push_seen}, 0);
    // R3 receive
    wr(12'h0, 32'h0000_8000);
    rx_empty = 0; rx_data = 8'h3C;
    rd(12'h4, r); chk("R3 char", r, 32'h3C); chk("R3 pop", {31'h0, pop_seen}, 1);
    rx_empty = 1; rx_data = 8'h77;
    rd(12'h4, r); chk("R3 empty zero", r, 0); chk("R3 no pop", {31'h0, pop_seen}, 0);
    // R4/R7 receive pending, sticky, set wins
    wr(12'h0, 32'h0004_8000);
    rx_empty = 0; @(negedge clk); @(negedge clk);
    chk("R7 rx irq", {31'h0, irq}, 1);
    rx_empty = 1; @(negedge clk);
    rd(12'hC, r); chk("R4 rx sticky", r[0], 1);
    chk("R7 irq sticky", {31'h0, irq}, 1);
    wr(12'hC, 32'h1); chk("R5 rx cleared irq", {31'h0, irq}, 0);
    rx_empty = 0;
    wr(12'hC, 32'h1); rd(12'hC, r); chk("R5 set wins", r[0], 1);
    rx_empty = 1; wr(12'hC, 32'h1);
    // R4/R7 transmit pending gated
    wr(12'h0, 32'h0008_8000); @(negedge clk);
    chk("R7 tx irq", {31'h0, irq}, 1);
    wr(12'h0, 32'h0000_8000);
    chk("R7 gated off", {31'h0, irq}, 0);
    rd(12'hC, r); chk("R4 tx sticky", r[1], 1);
    wr(12'hC, 32'h3); rd(12'hC, r); chk("R5 tx cleared", r[1:0], 0);
    // R6 event pulses
    @(negedge clk); ovr = 1; @(negedge clk); ovr = 0;
    rd(12'hC, r); chk("R6 overrun", r[4:2], 3'b001);
    @(negedge clk); ferr = 1; @(negedge clk); ferr = 0;
    rd(12'hC, r); chk("R6 frame err", r[4:2], 3'b101);
    chk("R7 no irq from errors", {31'h0, irq}, 0);
    wr(12'hC, 32'h14); rd(12'hC, r); chk("R5 errors cleared", r[4:0], 0);
    // R8 saturation and source select
    wr(12'h0, 32'h0000_C000); tx_cnt = 64; rx_cnt = 5;
    rd(12'hC, r); chk("R8 tx saturate", r[16:11], 63);
    wr(12'h0, 32'h0000_8000);
    rd(12'hC, r); chk("R8 rx level", r[16:11], 5);
    // random mix: R1, R8, R9
    for (int i = 0; i < 300; i++) begin
      cfg_w = (($urandom & CFG_MASK) & ~32'h000C_0000) | 32'h8000;
      wr(12'h0, cfg_w | (32'($urandom) & ~CFG_MASK));
      rd(12'h0, r); chk("R1 random cfg", r, cfg_w);
      tx_full = 1'($urandom); tx_empty = 1'($urandom); rx_empty = 1'($urandom);
      cts = 1'($urandom); rts = 1'($urandom); busy = 1'($urandom);
      tx_cnt = TXW'($urandom_range(0, TXD)); rx_cnt = RXW'($urandom_range(0, RXD));
      rd(12'hC, r); chk("R9 R8 random status", r, exp_stat(cfg_w, 5'h0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule